// File: doc/BRIEF.md
# Edge-Serviced Watchdog Monitor

This block watches a single service line that host software must keep toggling. Each rising or falling transition on that line restarts an internal cycle counter. If the counter runs for the full timeout without seeing a transition, an active-low status output drops and stays low until software toggles the line again. Holding the line still at either level therefore always ends in a timeout, and the check cannot be switched off.

The status output is meant to be looped back into the manual-reset input of a reset generator, so the reset-asserted status comes back in as an input. While reset is asserted the counter is held at zero and does not count. It starts counting on the first clock after reset is released. The status output is also pulled low directly, with no clock in the path, whenever the supply-valid flag is false. It returns high as soon as the flag is true again, unless a timeout is still pending.

The service line is asynchronous. It passes through a synchronizer whose depth is a parameter before its edges are detected. The timeout is given in clock cycles.

Top module: `wdg_edge_monitor`

## Requirements
- R1: With reset released, supply valid and no transition on the service line, `wdo_n_o` goes low after exactly TWD_CYCLES rising clock edges counted from the first edge at which `rst_active_i` is low, and not one edge earlier.
- R2: A rising transition and a falling transition on `wdi_i` both restart the count and release a pending timeout. With the default SYNC_STAGES of 2, the transition takes effect at the third rising clock edge after `wdi_i` changes.
- R3: While `rst_active_i` is high the counter stays at zero, so no timeout occurs however long reset lasts. Counting restarts from zero when reset is released.
- R4: After a timeout, `wdo_n_o` stays low for any number of further cycles until a transition on `wdi_i` takes effect. The counter saturates at its terminal value and does not wrap.
- R5: When `supply_ok_i` is low, `wdo_n_o` is low in the same cycle, with no clock edge needed. When `supply_ok_i` returns high, `wdo_n_o` goes high at once if no timeout is pending. The supply flag neither clears nor stops the counter.
- R6: When a transition takes effect at the same clock edge at which the counter sits at TWD_CYCLES-1, the transition wins and no timeout is raised.
- R7: A static high level and a static low level on `wdi_i` both lead to a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| wdi_i | input | 1 | Asynchronous service line toggled by host software |
| rst_active_i | input | 1 | High while the system reset is asserted; holds the counter at zero |
| supply_ok_i | input | 1 | High when the supply is above its threshold |
| wdo_n_o | output | 1 | Watchdog status, active low: low on timeout or when the supply is invalid |

## Verification
The bench sweeps the gap between service toggles across the terminal count. A design that gives the timeout priority over a same-cycle transition would drop the output in one of those runs. It also checks the exact cycle of the first timeout after reset release, which catches an off-by-one counter or a synchronizer that is one stage too short or too long. Long idle stretches after a timeout catch a counter that wraps and clears the pending state on its own. A reset longer than the timeout catches a timer that keeps counting under reset. Dropping the supply mid-count catches two faults: a registered supply path, which shows up before the clock edge, and a supply event that wrongly clears the timer, which shifts the later timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // Width of a counter that must hold values 0 .. n-1.
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("wdg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_edge_det.sv
module wdg_edge_det (
   input  logic clk_i,
   input  logic lvl_i,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk_i) begin
      prev_q <= lvl_i;
   end

   // either polarity counts as service
   assign edge_o = lvl_i ^ prev_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int TWD_CYCLES = 1000
) (
   input  logic clk_i,
   input  logic rst_active_i,
   input  logic edge_i,
   output logic expired_o
);
   localparam int CW = cnt_width(TWD_CYCLES);
   localparam logic [CW-1:0] TERM = CW'(TWD_CYCLES - 1);

   generate
      if (TWD_CYCLES < 2) begin : g_bad_timeout
         $error("wdg_timer: TWD_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          expired_q;
   logic          at_term;

   assign at_term = (cnt_q == TERM);

   always_ff @(posedge clk_i) begin
      if (rst_active_i || edge_i) begin
         cnt_q <= '0;
      end else if (!at_term) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // a pending timeout is released only by service, never by reset
   always_ff @(posedge clk_i) begin
      if (edge_i) begin
         expired_q <= 1'b0;
      end else if (!rst_active_i && at_term) begin
         expired_q <= 1'b1;
      end
   end

   assign expired_o = expired_q;

   a_r3_reset_holds_zero: assert property (@(posedge clk_i) disable iff (rst_active_i)
      $past(rst_active_i) |-> (cnt_q <= CW'(1)));

   a_r2_edge_clears: assert property (@(posedge clk_i) disable iff (rst_active_i)
      edge_i |=> (cnt_q == '0) && !expired_q);

   a_r1_timeout_only_at_term: assert property (@(posedge clk_i) disable iff (rst_active_i)
      $rose(expired_q) |-> $past(cnt_q == TERM));

   a_r4_timeout_sticky: assert property (@(posedge clk_i) disable iff (rst_active_i)
      (expired_q && !edge_i) |=> expired_q);

   a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (rst_active_i)
      (cnt_q == TERM && !edge_i) |=> (cnt_q == TERM));

   a_r6_edge_wins: assert property (@(posedge clk_i) disable iff (rst_active_i)
      edge_i |=> !$rose(expired_q));
endmodule

// File: rtl/wdg_edge_monitor.sv
module wdg_edge_monitor #(
   parameter int TWD_CYCLES  = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic wdi_i,
   input  logic rst_active_i,
   input  logic supply_ok_i,
   output logic wdo_n_o
);
   logic wdi_sync;
   logic wdi_edge;
   logic expired;

   wdg_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .d_i   (wdi_i),
      .q_o   (wdi_sync)
   );

   wdg_edge_det i_edge (
      .clk_i  (clk_i),
      .lvl_i  (wdi_sync),
      .edge_o (wdi_edge)
   );

   wdg_timer #(.TWD_CYCLES(TWD_CYCLES)) i_timer (
      .clk_i        (clk_i),
      .rst_active_i (rst_active_i),
      .edge_i       (wdi_edge),
      .expired_o    (expired)
   );

   // supply path is combinational: no hold time on recovery
   assign wdo_n_o = supply_ok_i & ~expired;

   a_r5_supply_low: assert property (@(posedge clk_i) disable iff (rst_active_i)
      !supply_ok_i |-> !wdo_n_o);

   a_r5_supply_recover: assert property (@(posedge clk_i) disable iff (rst_active_i)
      (supply_ok_i && !expired) |-> wdo_n_o);
endmodule

// File: tb/test_wdg_edge_monitor.sv
module test_wdg_edge_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int T = 20;

   logic clk = 1'b0;
   logic wdi = 1'b0;
   logic rst_act = 1'b1;
   logic ok = 1'b1;
   logic wdo_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdg_edge_monitor #(.TWD_CYCLES(T), .SYNC_STAGES(2)) i_wdg_edge_monitor (
      .clk_i        (clk),
      .wdi_i        (wdi),
      .rst_active_i (rst_act),
      .supply_ok_i  (ok),
      .wdo_n_o      (wdo_n)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;
   item_t sb_q[$];

   // requirement-level model: service takes effect 3 edges after a change
   int   m_cnt = 0;
   logic m_expired = 1'b0;
   logic w1 = 1'b0, w2 = 1'b0, w3 = 1'b0;
   logic lvl = 1'b0;

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: wdo_n=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic w, input logic r, input logic o, input string tag);
      logic e_now;
      logic term;
      item_t it;
      @(negedge clk);
      wdi = w; rst_act = r; ok = o;
      #1;
      // R5: supply acts before any clock edge
      check(wdo_n, o & ~m_expired, {tag, " / R5 before edge"});
      e_now = (w2 !== w3);
      term  = (m_cnt == T-1);
      if (e_now) m_expired = 1'b0;
      else if (!r && term) m_expired = 1'b1;
      if (r || e_now) m_cnt = 0;
      else if (!term) m_cnt++;
      w3 = w2; w2 = w1; w1 = w;
      it.exp = o & ~m_expired;
      it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk);
   endtask

   // monitor: pops expected values as the design produces them
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t got;
            got = sb_q.pop_front();
            check(wdo_n, got.exp, got.tag);
         end
      end
   end

   initial begin
      #(CLK_PERIOD*20000);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // reset, with a toggle inside it to settle the pending state
      repeat (3) cyc(1'b0, 1'b1, 1'b1, "R3 reset state");
      repeat (5) cyc(1'b1, 1'b1, 1'b1, "R3 reset state");
      lvl = 1'b1;

      // static high until timeout: exact cycle
      repeat (T+6) cyc(lvl, 1'b0, 1'b1, "R1 R7 static high timeout");
      repeat (3*T) cyc(lvl, 1'b0, 1'b1, "R4 stays low no wrap");

      // falling edge recovers
      lvl = ~lvl;
      repeat (T-5) cyc(lvl, 1'b0, 1'b1, "R2 falling edge service");

      // regular service, alternating polarity
      for (int r = 0; r < 4; r++) begin
         lvl = ~lvl;
         repeat (T-4) cyc(lvl, 1'b0, 1'b1, "R2 periodic service");
      end

      // static low until timeout
      repeat (T+6) cyc(lvl, 1'b0, 1'b1, "R7 static low timeout");
      lvl = ~lvl;
      repeat (4) cyc(lvl, 1'b0, 1'b1, "R2 rising edge service");

      // long reset with static line
      repeat (3*T) cyc(lvl, 1'b1, 1'b1, "R3 long reset no timeout");
      repeat (T+4) cyc(lvl, 1'b0, 1'b1, "R1 count from release");

      // sweep service gap across the terminal count
      for (int d = T-5; d <= T+1; d++) begin
         lvl = ~lvl;
         repeat (d) cyc(lvl, 1'b0, 1'b1, "R6 edge against terminal count");
      end

      // supply drop mid count, then recovery and unchanged timer
      lvl = ~lvl;
      repeat (5) cyc(lvl, 1'b0, 1'b1, "R5 before drop");
      repeat (6) cyc(lvl, 1'b0, 1'b0, "R5 supply low");
      repeat (T+4) cyc(lvl, 1'b0, 1'b1, "R5 recovery timer kept");

      // supply toggling while timed out keeps output low
      repeat (3) cyc(lvl, 1'b0, 1'b0, "R5 low during timeout");
      repeat (3) cyc(lvl, 1'b0, 1'b1, "R4 low after supply back");
      lvl = ~lvl;
      repeat (5) cyc(lvl, 1'b0, 1'b1, "R2 final service");

      repeat (3) @(posedge clk);
      #2;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule